// File: doc/BRIEF.md
# Sequential Masked Trigger Unit

This block watches a stream of 32-bit samples and decides when a logic-analyser capture starts. It walks through up to four trigger stages in order. Each stage holds a mask that picks which input lines matter and a value that gives the level each picked line must have. A sample that satisfies the current stage moves the unit on to the next stage. A stage whose start flag is set ends the search instead: the unit raises a one-cycle fire pulse and then holds a run level for a programmed number of further valid samples.

The unit sits idle after reset until software pulses `arm`. Pulsing `arm` again at any time restarts the search from stage 0. Because the match is delayed by one sample per stage walked, the unit reports how many stages took part (`trig_lag`). The capture side uses this to move the marked trigger point earlier by that many samples. A capture with no trigger uses an all-zero mask on stage 0 with its start flag set, so the first valid sample fires.

Top module: `trig_seq_unit`

## Requirements
- R1: After reset, `stage_idx` is 0 and `trig_fire`, `cap_run` and `trig_lag` are 0. The unit is idle until armed.
- R2: A stage matches when every line whose mask bit is 1 equals the matching value bit (1 = high, 0 = low). Lines whose mask bit is 0 are ignored.
- R3: While hunting, each valid sample that matches the current stage moves `stage_idx` up by exactly one. Samples with `smp_valid` low change nothing.
- R4: Bit s of `stg_start` is the start flag of stage s. A match on a stage with its flag set fires the trigger. A match on a stage without it only advances.
- R5: `trig_fire` is high for exactly one cycle, in the cycle after the edge that took the firing sample. It stays low afterwards until the unit is armed again.
- R6: A cycle with `arm` high returns `stage_idx` to 0 and clears `trig_fire`, `cap_run` and `trig_lag`. Samples seen before the first arm never advance or fire.
- R7: With stage 0 masked to all zeros and its start flag set, the first valid sample after arming fires.
- R8: On firing, `trig_lag` becomes the firing stage index plus one. It holds that value until the next arm or reset.
- R9: `cap_run` goes high together with `trig_fire` when `post_count` is non-zero. It falls after exactly `post_count` further valid samples. With `post_count` = 0 it never rises.
- R10: A match on the last stage without a start flag leaves `stage_idx` at the last stage and does not fire.
- R11: When `arm` and a matching valid sample occur in the same cycle, the arm wins and the sample is not evaluated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Restart the search at stage 0 |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 32 | Sample lines |
| stg_mask | input | 128 | Per-stage masks, stage s at bits [32s+31:32s] |
| stg_value | input | 128 | Per-stage required levels, same layout |
| stg_start | input | 4 | Per-stage start flag, bit s for stage s |
| post_count | input | 16 | Valid samples to record after the trigger |
| stage_idx | output | 2 | Stage currently searched |
| trig_fire | output | 1 | One-cycle trigger pulse |
| cap_run | output | 1 | High while post-trigger samples are counted |
| trig_lag | output | 3 | Stages used, reported at fire |

## Verification
A three-stage sequence is driven with samples that differ from a match only in masked lines, only in unmasked lines, and only in the strobe. This separates the mask logic from the level comparison and from the valid qualifier. Further patterns use all-zero masks with no start flag to show saturation at the last stage, and an immediate trigger to show the zero-length post window. An arm that coincides with a matching sample shows which of the two takes priority.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic [1:0] {
    TS_IDLE = 2'd0,
    TS_HUNT = 2'd1,
    TS_DONE = 2'd2
  } trig_state_t;

  function automatic int sel_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/trig_stage_match.sv
module trig_stage_match #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] value,
  output logic              hit
);
  // only lines picked by the mask must equal the programmed level
  always_comb hit = ~|((data ^ value) & mask);
endmodule

// File: rtl/trig_stage_seq.sv
module trig_stage_seq
  import trig_pkg::*;
#(
  parameter int NUM_STAGES = 4,
  parameter int SEL_W      = 2,
  parameter int LAG_W      = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  arm,
  input  logic                  smp_valid,
  input  logic [NUM_STAGES-1:0] hit_vec,
  input  logic [NUM_STAGES-1:0] start_vec,
  output logic [SEL_W-1:0]      stage_q,
  output logic                  fire_q,
  output logic [LAG_W-1:0]      lag_q,
  output logic                  fire_now
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(NUM_STAGES - 1);

  trig_state_t state_q;
  logic        cur_hit;
  logic        cur_start;

  always_comb begin
    cur_hit   = hit_vec[stage_q];
    cur_start = start_vec[stage_q];
    fire_now  = (state_q == TS_HUNT) && !arm && smp_valid && cur_hit && cur_start;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TS_IDLE;
      stage_q <= '0;
      fire_q  <= 1'b0;
      lag_q   <= '0;
    end else begin
      fire_q <= 1'b0;
      if (arm) begin
        state_q <= TS_HUNT;
        stage_q <= '0;
        lag_q   <= '0;
      end else if (state_q == TS_HUNT && smp_valid && cur_hit) begin
        if (cur_start) begin
          state_q <= TS_DONE;
          fire_q  <= 1'b1;
          lag_q   <= LAG_W'(stage_q) + LAG_W'(1);
        end else if (stage_q != LAST) begin
          stage_q <= stage_q + SEL_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/trig_post_counter.sv
module trig_post_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             fire_now,
  input  logic             smp_valid,
  input  logic [CNT_W-1:0] post_count,
  output logic             run_q
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      limit_q <= '0;
    end else if (arm) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (fire_now) begin
      run_q   <= (post_count != '0);
      cnt_q   <= '0;
      limit_q <= post_count;
    end else if (run_q && smp_valid) begin
      if (cnt_q + CNT_W'(1) == limit_q) run_q <= 1'b0;
      else cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/trig_seq_unit.sv
module trig_seq_unit
  import trig_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_STAGES = 4,
  parameter int CNT_W      = 16,
  parameter int SEL_W      = sel_width(NUM_STAGES),
  parameter int LAG_W      = SEL_W + 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         arm,
  input  logic                         smp_valid,
  input  logic [DATA_W-1:0]            smp_data,
  input  logic [NUM_STAGES*DATA_W-1:0] stg_mask,
  input  logic [NUM_STAGES*DATA_W-1:0] stg_value,
  input  logic [NUM_STAGES-1:0]        stg_start,
  input  logic [CNT_W-1:0]             post_count,
  output logic [SEL_W-1:0]             stage_idx,
  output logic                         trig_fire,
  output logic                         cap_run,
  output logic [LAG_W-1:0]             trig_lag
);
  logic [NUM_STAGES-1:0] hit_vec;
  logic                  fire_now;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    trig_stage_match #(.DATA_W(DATA_W)) u_match (
      .data  (smp_data),
      .mask  (stg_mask[s*DATA_W +: DATA_W]),
      .value (stg_value[s*DATA_W +: DATA_W]),
      .hit   (hit_vec[s])
    );
  end

  trig_stage_seq #(
    .NUM_STAGES(NUM_STAGES), .SEL_W(SEL_W), .LAG_W(LAG_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .arm       (arm),
    .smp_valid (smp_valid),
    .hit_vec   (hit_vec),
    .start_vec (stg_start),
    .stage_q   (stage_idx),
    .fire_q    (trig_fire),
    .lag_q     (trig_lag),
    .fire_now  (fire_now)
  );

  trig_post_counter #(.CNT_W(CNT_W)) u_post (
    .clk        (clk),
    .rst        (rst),
    .arm        (arm),
    .fire_now   (fire_now),
    .smp_valid  (smp_valid),
    .post_count (post_count),
    .run_q      (cap_run)
  );
endmodule

// File: rtl/trig_seq_unit_chk.sv
module trig_seq_unit_chk #(
  parameter int SEL_W = 2,
  parameter int LAG_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             arm,
  input logic             smp_valid,
  input logic [SEL_W-1:0] stage_idx,
  input logic             trig_fire,
  input logic             cap_run,
  input logic [LAG_W-1:0] trig_lag
);
  // R3: no strobe, no arm -> stage held
  a_r3_hold_no_valid: assert property (@(posedge clk) disable iff (rst)
    (!arm && !smp_valid) |=> $stable(stage_idx));

  // R3: stage never moves by more than one step
  a_r3_step_one: assert property (@(posedge clk) disable iff (rst)
    !arm |=> (SEL_W'(stage_idx - $past(stage_idx)) <= SEL_W'(1)));

  // R5: fire pulse lasts one cycle
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    trig_fire |=> !trig_fire);

  // R6 and R11: arm restarts cleanly even with a matching sample
  a_r6_arm_clears: assert property (@(posedge clk) disable iff (rst)
    arm |=> (stage_idx == '0 && !trig_fire && !cap_run && trig_lag == '0));

  // R8: reported lag equals stages walked at fire time
  a_r8_lag_at_fire: assert property (@(posedge clk) disable iff (rst)
    trig_fire |-> (trig_lag == LAG_W'(stage_idx) + LAG_W'(1)));

  // R9: run window ends only on a counted sample or an arm
  a_r9_fall_on_valid: assert property (@(posedge clk) disable iff (rst)
    $fell(cap_run) |-> ($past(smp_valid) || $past(arm)));
endmodule

bind trig_seq_unit trig_seq_unit_chk #(.SEL_W(SEL_W), .LAG_W(LAG_W)) u_chk (
  .clk(clk), .rst(rst), .arm(arm), .smp_valid(smp_valid),
  .stage_idx(stage_idx), .trig_fire(trig_fire), .cap_run(cap_run),
  .trig_lag(trig_lag)
);

// File: tb/trig_seq_unit_tb.sv
`timescale 1ns/1ps
module trig_seq_unit_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         arm = 1'b0;
  logic         smp_valid = 1'b0;
  logic [31:0]  smp_data = '0;
  logic [127:0] stg_mask = '0;
  logic [127:0] stg_value = '0;
  logic [3:0]   stg_start = '0;
  logic [15:0]  post_count = '0;
  logic [1:0]   stage_idx;
  logic         trig_fire;
  logic         cap_run;
  logic [2:0]   trig_lag;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  trig_seq_unit u_dut (
    .clk(clk), .rst(rst), .arm(arm), .smp_valid(smp_valid), .smp_data(smp_data),
    .stg_mask(stg_mask), .stg_value(stg_value), .stg_start(stg_start),
    .post_count(post_count), .stage_idx(stage_idx), .trig_fire(trig_fire),
    .cap_run(cap_run), .trig_lag(trig_lag)
  );

  // fields: [37] arm [36] valid [35:4] data [3:2] stage [1] fire [0] run
  localparam logic [37:0] VEC [12] = '{
    {1'b1, 1'b0, 32'h0000_0000, 2'd0, 1'b0, 1'b0},
    {1'b0, 1'b1, 32'h0000_005B, 2'd0, 1'b0, 1'b0},
    {1'b0, 1'b0, 32'h0000_005A, 2'd0, 1'b0, 1'b0},
    {1'b0, 1'b1, 32'hFFFF_FF5A, 2'd1, 1'b0, 1'b0},
    {1'b0, 1'b1, 32'h2000_005A, 2'd1, 1'b0, 1'b0},
    {1'b0, 1'b1, 32'h3ABC_DEF0, 2'd2, 1'b0, 1'b0},
    {1'b0, 1'b1, 32'h0000_0000, 2'd2, 1'b0, 1'b0},
    {1'b0, 1'b1, 32'h0001_0000, 2'd2, 1'b1, 1'b1},
    {1'b0, 1'b1, 32'h0001_0000, 2'd2, 1'b0, 1'b1},
    {1'b0, 1'b0, 32'h0000_0000, 2'd2, 1'b0, 1'b1},
    {1'b0, 1'b1, 32'h0000_0000, 2'd2, 1'b0, 1'b1},
    {1'b0, 1'b1, 32'h0000_0000, 2'd2, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic a, input logic v, input logic [31:0] d);
    arm = a; smp_valid = v; smp_data = d;
    @(posedge clk);
    @(negedge clk);
    arm = 1'b0; smp_valid = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    stg_mask  = {32'h0, 32'h0001_0000, 32'hF000_0000, 32'h0000_00FF};
    stg_value = {32'h0, 32'h0001_0000, 32'h3000_0000, 32'h0000_005A};
    stg_start = 4'b0100;
    post_count = 16'd3;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 stage", 32'(stage_idx), 0);
    chk("R1 fire", 32'(trig_fire), 0);
    chk("R1 run", 32'(cap_run), 0);
    chk("R1 lag", 32'(trig_lag), 0);

    // R6: unarmed unit ignores a matching sample
    tick(1'b0, 1'b1, 32'h0000_005A);
    chk("R6 idle stage", 32'(stage_idx), 0);
    chk("R6 idle fire", 32'(trig_fire), 0);

    // table: R2 R3 R4 R5 R9
    for (int i = 0; i < 12; i++) begin
      tick(VEC[i][37], VEC[i][36], VEC[i][35:4]);
      chk($sformatf("R2/R3/R4 stage step %0d", i), 32'(stage_idx), 32'(VEC[i][3:2]));
      chk($sformatf("R4/R5 fire step %0d", i), 32'(trig_fire), 32'(VEC[i][1]));
      chk($sformatf("R9 run step %0d", i), 32'(cap_run), 32'(VEC[i][0]));
    end
    chk("R8 lag after third stage", 32'(trig_lag), 3);

    // R6 and R8: re-arm clears lag and stage
    tick(1'b1, 1'b0, 32'h0);
    chk("R6 rearm stage", 32'(stage_idx), 0);
    chk("R8 rearm lag", 32'(trig_lag), 0);

    // R10: no start flag anywhere, all masks open
    stg_mask = '0; stg_value = '0; stg_start = 4'b0000;
    tick(1'b1, 1'b0, 32'h0);
    for (int k = 0; k < 5; k++) tick(1'b0, 1'b1, 32'h1234_5678);
    chk("R10 saturate stage", 32'(stage_idx), 3);
    chk("R10 no fire", 32'(trig_fire), 0);

    // R11: arm with a matching sample, then R7 immediate trigger
    stg_start = 4'b0001; post_count = 16'd0;
    tick(1'b1, 1'b1, 32'hDEAD_BEEF);
    chk("R11 arm wins fire", 32'(trig_fire), 0);
    chk("R11 arm wins stage", 32'(stage_idx), 0);
    tick(1'b0, 1'b1, 32'hDEAD_BEEF);
    chk("R7 immediate fire", 32'(trig_fire), 1);
    chk("R8 lag one stage", 32'(trig_lag), 1);
    chk("R9 zero window run", 32'(cap_run), 0);
    tick(1'b0, 1'b1, 32'hDEAD_BEEF);
    chk("R5 no refire", 32'(trig_fire), 0);
    chk("R8 lag held", 32'(trig_lag), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule